// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels behind a byte-wide register port. Each channel counts one of two sources. The first is an internal tick that fires once every twelve clocks. The second is the falling edges of its own event pin. Each channel can also be gated by a level input, so that it counts only while that input is high. A counter that wraps sets the channel's overflow flag and raises a one-clock overflow pulse, which a serial-rate generator can use. The flag stays set until an acknowledge strobe or a software write clears it.

A mode field selects one of four counting structures over the same pair of bytes:
- a 13-bit count, in which the low byte's bottom five bits act as a prescaler;
- a full 16-bit count;
- an 8-bit count that reloads from the high byte;
- a split mode, in which channel 0 becomes two independent 8-bit counters.

In split mode the upper half of channel 0 takes over channel 1's run bit and overflow flag, and channel 1 stops.

Software sets the channel configuration first, then loads the count bytes, then sets the run bits. It reads the counts and flags back through the same port.

Top module: `twin_timer`

## Requirements
- R1: After reset, every register reads 0 and both overflow flags and both overflow pulses are low.
- R2: The register map is as follows.
  - Address 0 is the configuration byte. Channel 0 uses bits 3:0 and channel 1 uses bits 7:4. In each nibble, bit 3 is the gate enable, bit 2 selects the event pin as the source (0 selects the tick), and bits 1:0 are the mode.
  - Address 1 is the control byte: bit 0 is run0, bit 1 is run1, bit 4 is flag0 and bit 5 is flag1. Its other bits read 0.
  - Addresses 2 and 3 are channel 0 low and high. Addresses 4 and 5 are channel 1 low and high. Addresses 6 and 7 read 0.
  - A byte write takes effect in the same edge as any count and overrides it: a write to either byte of a channel suppresses that channel's count on that edge.
- R3: The internal source advances a tick-driven counter exactly once every 12 clocks.
- R4: Mode 0 counts in the low 5 bits of the low byte. A carry out of those bits increments the high byte, and bits 7:5 of the low byte are left unchanged. The channel overflows when the high byte is 0xFF and the low 5 bits are 0x1F.
- R5: Mode 1 counts {high, low} as one 16-bit value and overflows on the step from 0xFFFF to 0x0000.
- R6: Mode 2 counts the low byte. On the step from 0xFF it loads the high byte into the low byte and overflows; the high byte is unchanged.
- R7: Mode 3 on channel 0 behaves as two 8-bit counters.
  - The low byte counts under channel 0's source, gate and run bit, and sets flag0.
  - The high byte counts ticks under run1 only and sets flag1.
  - Channel 1 holds its count while channel 0 is in mode 3, and also while channel 1's own mode is 3.
- R8: A channel counts only while its run bit is 1. With the gate bit set, it counts only while its synchronized gate pin is also high.
- R9: With the source select set, the channel counts one event per falling edge of its event pin. An edge is recognised when the synchronized pin is high at one tick and low at the next.
- R10: An overflow sets the channel's flag. A flag acknowledge strobe clears it. A control-byte write loads it. Overflow wins over acknowledge, and acknowledge wins over the write.
- R11: Each overflow gives a one-clock pulse on the channel's pulse output, on the same edge that sets its flag. Channel 1's pulse comes from the upper half when channel 0 is in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data, combinational from bus_addr |
| evt_pin | input | 2 | Per-channel external event pins |
| gate_pin | input | 2 | Per-channel gate (interrupt) level pins |
| flag_ack | input | 2 | Per-channel flag clear strobes |
| ovf_flag | output | 2 | Per-channel overflow flags |
| ovf_pulse | output | 2 | Per-channel one-clock overflow pulses |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 5-bit prescaler, a tick divider of 12 and two synchronizer stages. With a divider of 12, a full 256-step wrap of the 8-bit reload mode takes about 3,100 clocks, so the bench can reach the second reload. The 13-bit and 16-bit overflows become reachable by preloading counts a few steps short of their terminal values. With two-stage synchronizers and pin levels held for 40 clocks, every falling edge crosses two ticks, so the expected edge count is exact.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

   // Counting structure selected per channel
   typedef enum logic [1:0] {
      MD_PRE13   = 2'd0,
      MD_FULL16  = 2'd1,
      MD_RELOAD8 = 2'd2,
      MD_SPLIT   = 2'd3
   } tmode_e;

   // One configuration nibble: gate at bit 3, source select at bit 2
   typedef struct packed {
      logic   gate;
      logic   ext_sel;
      tmode_e mode;
   } chan_cfg_t;

   localparam logic [2:0] A_MODE = 3'd0;
   localparam logic [2:0] A_CTRL = 3'd1;
   localparam logic [2:0] A_C0LO = 3'd2;

endpackage

// File: rtl/twin_timer_tick.sv
module twin_timer_tick #(
   parameter int unsigned DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   initial assert (DIV >= 2) else $error("twin_timer_tick: DIV must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q == LAST)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);
endmodule

// File: rtl/twin_timer_pinsync.sv
module twin_timer_pinsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic evt_pin,
   input  logic gate_pin,
   output logic evt_fall,
   output logic gate_lvl
);
   logic [STAGES-1:0] ev_sh;
   logic [STAGES-1:0] gt_sh;
   logic              ev_prev;

   initial assert (STAGES >= 2) else $error("twin_timer_pinsync: STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_sh   <= '0;
         gt_sh   <= '0;
         ev_prev <= 1'b0;
      end else begin
         ev_sh <= {ev_sh[STAGES-2:0], evt_pin};
         gt_sh <= {gt_sh[STAGES-2:0], gate_pin};
         if (tick)
            ev_prev <= ev_sh[STAGES-1];
      end
   end

   // High at the previous tick, low at this one
   assign evt_fall = tick & ev_prev & ~ev_sh[STAGES-1];
   assign gate_lvl = gt_sh[STAGES-1];
endmodule

// File: rtl/twin_timer_core.sv
module twin_timer_core
   import twin_timer_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned PRE_W     = 5,
   parameter bit          HAS_SPLIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmode_e            mode,
   input  logic              cnt_en,
   input  logic              hi_cnt_en,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] lo_q,
   output logic [BYTE_W-1:0] hi_q,
   output logic              ovf_main,
   output logic              ovf_upper
);
   logic [BYTE_W-1:0] lo_d, hi_d;
   logic              split, main_go, up_go;

   initial assert (PRE_W >= 1 && PRE_W < BYTE_W)
      else $error("twin_timer_core: PRE_W must lie in 1..BYTE_W-1");

   generate
      if (HAS_SPLIT) begin : g_split
         assign split = (mode == MD_SPLIT);
      end else begin : g_nosplit
         assign split = 1'b0;
      end
   endgenerate

   // A channel without the split variant holds in mode 3
   assign main_go = cnt_en & ~wr_lo & ~(wr_hi & ~split)
                  & ((mode != MD_SPLIT) | split);
   assign up_go   = split & hi_cnt_en & ~wr_hi;

   always_comb begin
      lo_d      = lo_q;
      hi_d      = hi_q;
      ovf_main  = 1'b0;
      ovf_upper = 1'b0;
      if (main_go) begin
         case (mode)
            MD_PRE13: begin
               lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
               if (&lo_q[PRE_W-1:0]) begin
                  hi_d     = hi_q + 1'b1;
                  ovf_main = &hi_q;
               end
            end
            MD_FULL16: begin
               {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
               ovf_main     = &{hi_q, lo_q};
            end
            MD_RELOAD8: begin
               if (&lo_q) begin
                  lo_d     = hi_q;
                  ovf_main = 1'b1;
               end else begin
                  lo_d = lo_q + 1'b1;
               end
            end
            default: begin
               lo_d     = lo_q + 1'b1;
               ovf_main = &lo_q;
            end
         endcase
      end
      if (up_go) begin
         hi_d      = hi_q + 1'b1;
         ovf_upper = &hi_q;
      end
      if (wr_lo) lo_d = wdata;
      if (wr_hi) hi_d = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
   import twin_timer_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned PRE_W       = 5,
   parameter int unsigned TICK_DIV    = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic [1:0]        evt_pin,
   input  logic [1:0]        gate_pin,
   input  logic [1:0]        flag_ack,
   output logic [1:0]        ovf_flag,
   output logic [1:0]        ovf_pulse
);
   localparam int unsigned NCH = 2;

   logic [7:0]                   mode_q;
   logic [NCH-1:0]               run_q, flag_q, pulse_q;
   logic                         tick, split0;
   logic [NCH-1:0]               evt_fall, gate_lvl, ovf_main, ovf_upper, ev;
   logic [NCH-1:0][BYTE_W-1:0]   lo_q, hi_q;
   chan_cfg_t                    cfg [NCH];
   logic                         wr_mode, wr_ctrl;

   initial assert (BYTE_W >= 8) else $error("twin_timer: BYTE_W must be at least 8");

   twin_timer_tick #(.DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   assign wr_mode = bus_wr && (bus_addr == A_MODE);
   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign split0  = (cfg[0].mode == MD_SPLIT);

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         localparam logic [2:0] LO_A = 3'(A_C0LO + 2 * c);
         localparam logic [2:0] HI_A = 3'(A_C0LO + 2 * c + 1);
         logic src_ev, allow, cnt_en;

         assign cfg[c] = chan_cfg_t'(mode_q[4*c +: 4]);

         twin_timer_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .evt_pin (evt_pin[c]),
            .gate_pin(gate_pin[c]),
            .evt_fall(evt_fall[c]),
            .gate_lvl(gate_lvl[c])
         );

         assign src_ev = cfg[c].ext_sel ? evt_fall[c] : tick;
         assign allow  = run_q[c] & (~cfg[c].gate | gate_lvl[c]);
         // Channel 1 stops while channel 0 is split
         assign cnt_en = allow & src_ev & ((c == 0) | ~split0);

         twin_timer_core #(
            .BYTE_W   (BYTE_W),
            .PRE_W    (PRE_W),
            .HAS_SPLIT(c == 0)
         ) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (cfg[c].mode),
            .cnt_en   (cnt_en),
            .hi_cnt_en(tick & run_q[1]),
            .wr_lo    (bus_wr && (bus_addr == LO_A)),
            .wr_hi    (bus_wr && (bus_addr == HI_A)),
            .wdata    (bus_wdata),
            .lo_q     (lo_q[c]),
            .hi_q     (hi_q[c]),
            .ovf_main (ovf_main[c]),
            .ovf_upper(ovf_upper[c])
         );
      end
   endgenerate

   // Channel 1's events come from the split upper half when channel 0 is in mode 3
   assign ev[0] = ovf_main[0];
   assign ev[1] = ovf_main[1] | ovf_upper[0] | ovf_upper[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         run_q   <= '0;
         flag_q  <= '0;
         pulse_q <= '0;
      end else begin
         if (wr_mode) mode_q <= bus_wdata[7:0];
         if (wr_ctrl) run_q  <= bus_wdata[1:0];
         for (int c = 0; c < NCH; c++) begin
            if (ev[c])
               flag_q[c] <= 1'b1;
            else if (flag_ack[c])
               flag_q[c] <= 1'b0;
            else if (wr_ctrl)
               flag_q[c] <= bus_wdata[4+c];
         end
         pulse_q <= ev;
      end
   end

   always_comb begin
      case (bus_addr)
         3'd0:    bus_rdata = BYTE_W'(mode_q);
         3'd1:    bus_rdata = BYTE_W'({2'b00, flag_q, 2'b00, run_q});
         3'd2:    bus_rdata = lo_q[0];
         3'd3:    bus_rdata = hi_q[0];
         3'd4:    bus_rdata = lo_q[1];
         3'd5:    bus_rdata = hi_q[1];
         default: bus_rdata = '0;
      endcase
   end

   assign ovf_flag  = flag_q;
   assign ovf_pulse = pulse_q;
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk #(
   parameter int unsigned BYTE_W = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_wr,
   input logic [2:0]                 bus_addr,
   input logic [1:0]                 flag_ack,
   input logic [1:0]                 ovf_flag,
   input logic [1:0]                 ovf_pulse,
   input logic [7:0]                 mode_q,
   input logic [1:0]                 run_q,
   input logic [1:0]                 gate_lvl,
   input logic [1:0][BYTE_W-1:0]     lo_q,
   input logic [1:0][BYTE_W-1:0]     hi_q
);
   logic wr_ctl, wr_c0lo, wr_c1;
   assign wr_ctl  = bus_wr && (bus_addr == 3'd1);
   assign wr_c0lo = bus_wr && (bus_addr == 3'd2);
   assign wr_c1   = bus_wr && ((bus_addr == 3'd4) || (bus_addr == 3'd5));

   // R8: a stopped channel 0 keeps its low byte
   assert_run_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[0] && !wr_c0lo) |=> (lo_q[0] == $past(lo_q[0])));

   // R8: gate set with a low gate level keeps the low byte
   assert_gate_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[3] && !gate_lvl[0] && !wr_c0lo) |=> (lo_q[0] == $past(lo_q[0])));

   // R7: channel 1 holds while channel 0 is split
   assert_ch1_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q[1:0] == 2'd3) && !wr_c1) |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

   generate
      for (genvar c = 0; c < 2; c++) begin : g_chk
         // R11: pulse lasts one clock and coincides with a set flag
         assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_pulse[c] |=> !ovf_pulse[c]);
         assert_pulse_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_pulse[c] |-> ovf_flag[c]);
         // R10: acknowledge clears unless a new overflow lands
         assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_ack[c] && !wr_ctl) |=> (!ovf_flag[c] || ovf_pulse[c]));
         // R10: a set flag stays set without acknowledge or write
         assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_flag[c] && !flag_ack[c] && !wr_ctl) |=> ovf_flag[c]);
      end
   endgenerate
endmodule

bind twin_timer twin_timer_chk #(.BYTE_W(BYTE_W)) u_twin_timer_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .flag_ack (flag_ack),
   .ovf_flag (ovf_flag),
   .ovf_pulse(ovf_pulse),
   .mode_q   (mode_q),
   .run_q    (run_q),
   .gate_lvl (gate_lvl),
   .lo_q     (lo_q),
   .hi_q     (hi_q)
);

// File: tb/test_twin_timer.sv
`timescale 1ns/1ps
module test_twin_timer;
   localparam int TICK_DIV = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic [1:0] evt_pin = 2'b00;
   logic [1:0] gate_pin = 2'b00;
   logic [1:0] flag_ack = 2'b00;
   logic [1:0] ovf_flag, ovf_pulse;

   int    n_checks = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   bit    started = 1'b0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   twin_timer i_twin_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pin(evt_pin),
      .gate_pin(gate_pin), .flag_ack(flag_ack), .ovf_flag(ovf_flag),
      .ovf_pulse(ovf_pulse)
   );

   // ---------------- behavioural reference model ----------------
   int               m_div;
   logic [7:0]       m_mode;
   logic [1:0]       m_run, m_flag, m_pulse, ev, en, wl, wh;
   logic [1:0][7:0]  m_lo, m_hi, nlo, nhi;
   logic [1:0][1:0]  m_es, m_gs;
   logic [1:0]       m_prev;
   bit               tk, sp, hold, blocked;
   int               v;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_div = 0; m_mode = 0; m_run = 0; m_flag = 0; m_pulse = 0;
         m_lo = '0; m_hi = '0; m_es = '0; m_gs = '0; m_prev = 0;
      end else begin
         tk = (m_div == TICK_DIV - 1);
         sp = (m_mode[1:0] == 2'd3);
         for (int c = 0; c < 2; c++) begin
            en[c] = m_run[c] && (!m_mode[4*c+3] || m_gs[c][1]) &&
                    (m_mode[4*c+2] ? (tk && m_prev[c] && !m_es[c][1]) : tk);
            wl[c] = bus_wr && (bus_addr == 3'(2 + 2*c));
            wh[c] = bus_wr && (bus_addr == 3'(3 + 2*c));
         end
         ev = 0; nlo = m_lo; nhi = m_hi;
         for (int c = 0; c < 2; c++) begin
            hold    = (c == 1) && (sp || m_mode[5:4] == 2'd3);
            blocked = wl[c] || (wh[c] && !(c == 0 && sp));
            if (en[c] && !hold && !blocked) begin
               case (m_mode[4*c +: 2])
                  2'd0: begin
                     v = m_lo[c] % 32 + 1;
                     if (v == 32) begin
                        nlo[c] = m_lo[c] - 8'd31;
                        if (m_hi[c] == 8'hFF) ev[c] = 1;
                        nhi[c] = m_hi[c] + 8'd1;
                     end else nlo[c] = m_lo[c] + 8'd1;
                  end
                  2'd1: begin
                     v = m_hi[c] * 256 + m_lo[c] + 1;
                     if (v == 65536) begin ev[c] = 1; v = 0; end
                     nlo[c] = 8'(v % 256); nhi[c] = 8'(v / 256);
                  end
                  2'd2: begin
                     if (m_lo[c] == 8'hFF) begin nlo[c] = m_hi[c]; ev[c] = 1; end
                     else nlo[c] = m_lo[c] + 8'd1;
                  end
                  default: begin
                     if (m_lo[c] == 8'hFF) ev[c] = 1;
                     nlo[c] = m_lo[c] + 8'd1;
                  end
               endcase
            end
         end
         if (sp && tk && m_run[1] && !wh[0]) begin
            if (m_hi[0] == 8'hFF) ev[1] = 1;
            nhi[0] = m_hi[0] + 8'd1;
         end
         for (int c = 0; c < 2; c++) begin
            if (wl[c]) nlo[c] = bus_wdata;
            if (wh[c]) nhi[c] = bus_wdata;
            if (ev[c]) m_flag[c] = 1;
            else if (flag_ack[c]) m_flag[c] = 0;
            else if (bus_wr && bus_addr == 3'd1) m_flag[c] = bus_wdata[4+c];
            if (tk) m_prev[c] = m_es[c][1];
            m_es[c] = {m_es[c][0], evt_pin[c]};
            m_gs[c] = {m_gs[c][0], gate_pin[c]};
         end
         if (bus_wr && bus_addr == 3'd0) m_mode = bus_wdata;
         if (bus_wr && bus_addr == 3'd1) m_run = bus_wdata[1:0];
         m_pulse = ev; m_lo = nlo; m_hi = nhi;
         m_div = tk ? 0 : m_div + 1;
      end
   end

   function automatic logic [7:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_mode;
         3'd1: return {2'b00, m_flag, 2'b00, m_run};
         3'd2: return m_lo[0];
         3'd3: return m_hi[0];
         3'd4: return m_lo[1];
         3'd5: return m_hi[1];
         default: return 8'h00;
      endcase
   endfunction

   // compare with the model on every clock
   always @(posedge clk) begin
      #1;
      if (started && rst_n && !done) begin
         n_checks++;
         if (bus_rdata !== m_read(bus_addr) || ovf_flag !== m_flag || ovf_pulse !== m_pulse) begin
            n_fail++;
            $display("FAIL %s cycle compare at %0t: rdata/flag/pulse actual %h/%b/%b expected %h/%b/%b",
                     cur_req, $time, bus_rdata, ovf_flag, ovf_pulse, m_read(bus_addr), m_flag, m_pulse);
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); bus_addr = a; #1;
      chk(bus_rdata, exp, tag);
   endtask

   task automatic wait_pulse(input int c, input int lim, input string tag);
      for (int k = 0; k < lim; k++) begin
         @(negedge clk);
         if (ovf_pulse[c]) return;
      end
      chk(0, 1, {tag, " overflow pulse never seen"});
   endtask

   task automatic ack(input logic [1:0] m);
      @(negedge clk); flag_ack = m;
      @(negedge clk); flag_ack = 2'b00;
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(4 * 190000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      finish_up();
   end

   // ---------------- stimulus ----------------
   logic [7:0] held;
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      started = 1'b1;

      // R1 / R2: reset values and unmapped addresses
      for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1");
      chk(ovf_flag, 2'b00, "R1 flags");
      chk(ovf_pulse, 2'b00, "R1 pulses");

      // R5, R10, R11: 16-bit overflow on channel 0
      cur_req = "R5";
      wr(0, 8'h01); wr(3, 8'hFF); wr(2, 8'hFE); wr(1, 8'h01);
      wait_pulse(0, 100, "R5");
      @(negedge clk); chk(ovf_pulse[0], 1'b0, "R11 pulse one clock");
      rd(2, 8'h00, "R5 low after wrap"); rd(3, 8'h00, "R5 high after wrap");
      rd(1, 8'h11, "R10 flag0 set");
      cur_req = "R10";
      ack(2'b01);
      rd(1, 8'h01, "R10 ack clears flag0");

      // R3: ten ticks in 120 clocks
      cur_req = "R3";
      wr(1, 8'h00); wr(3, 8'h00); wr(2, 8'h00); wr(1, 8'h01);
      repeat (119) @(negedge clk);
      rd(2, 8'h0A, "R3 tick rate");
      wr(1, 8'h00);

      // R4: 13-bit mode on channel 1, upper low-byte bits kept
      cur_req = "R4";
      wr(0, 8'h00); wr(5, 8'hFF); wr(4, 8'hFD); wr(1, 8'h02);
      wait_pulse(1, 100, "R4");
      rd(4, 8'hE0, "R4 low after wrap"); rd(5, 8'h00, "R4 high after wrap");
      rd(1, 8'h22, "R10 flag1 set");
      cur_req = "R10";
      wr(1, 8'h30); rd(1, 8'h30, "R10 software set");
      wr(1, 8'h00); rd(1, 8'h00, "R10 software clear");

      // R6: reload mode
      cur_req = "R6";
      wr(0, 8'h02); wr(3, 8'h80); wr(2, 8'hFF); wr(1, 8'h01);
      wait_pulse(0, 40, "R6");
      rd(2, 8'h80, "R6 reload"); rd(3, 8'h80, "R6 high unchanged");
      wait_pulse(0, 2000, "R6");
      rd(2, 8'h80, "R6 second reload");
      wr(1, 8'h00);

      // R8: gating and run bit
      cur_req = "R8";
      gate_pin = 2'b00;
      wr(0, 8'h09); wr(3, 8'h00); wr(2, 8'h00); wr(1, 8'h01);
      repeat (99) @(negedge clk);
      rd(2, 8'h00, "R8 gate low blocks counting");
      gate_pin[0] = 1'b1;
      repeat (60) @(negedge clk);
      wr(1, 8'h00);
      @(negedge clk); bus_addr = 3'd2; #1; held = bus_rdata;
      repeat (60) @(negedge clk);
      rd(2, held, "R8 run off holds count");
      gate_pin = 2'b00;

      // R9: external falling edges on channel 1
      cur_req = "R9";
      wr(0, 8'h50); wr(5, 8'h00); wr(4, 8'h00); wr(1, 8'h02);
      for (int k = 0; k < 5; k++) begin
         evt_pin[1] = 1'b1; repeat (40) @(negedge clk);
         evt_pin[1] = 1'b0; repeat (40) @(negedge clk);
      end
      rd(4, 8'h05, "R9 five falling edges");
      wr(1, 8'h00);

      // R2: write overrides a count on the same edge (model-checked)
      cur_req = "R2";
      wr(0, 8'h01); wr(1, 8'h01);
      for (int k = 0; k < 30; k++) wr(2, 8'h40);
      rd(2, 8'h40, "R2 write wins over counting");
      wr(1, 8'h00);

      // R7: split mode on channel 0, channel 1 frozen
      cur_req = "R7";
      wr(4, 8'h33); wr(5, 8'h44); wr(0, 8'h13);
      wr(2, 8'hFE); wr(3, 8'hFD); wr(1, 8'h03);
      repeat (60) @(negedge clk);
      rd(1, 8'h33, "R7 both flags from split halves");
      rd(4, 8'h33, "R7 ch1 low held"); rd(5, 8'h44, "R7 ch1 high held");
      wr(1, 8'h00);
      cur_req = "R11";
      ack(2'b11);
      cur_req = "R7";
      wr(0, 8'h30); wr(4, 8'h10); wr(1, 8'h02);
      repeat (40) @(negedge clk);
      rd(4, 8'h10, "R7 ch1 own mode 3 holds");
      wr(1, 8'h00);

      repeat (5) @(negedge clk);
      finish_up();
   end
endmodule